// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block presents the management registers of a 10/100 Ethernet transceiver to a MAC over a simple synchronous parallel port: a 5-bit register address, 16-bit write data with a write strobe, and a read strobe whose data appears registered on the following clock edge. It holds control, status, advertisement, interrupt-cause and interrupt-mask registers. It also answers fixed identifier, link-partner and expansion words. Negotiation is modelled as finishing at once, so enabling it or seeing the link rise marks it complete.

A link-level input is passed through a synchroniser. Each change of its settled level updates the link and negotiation status bits and latches interrupt causes. A level interrupt output is raised while any latched cause is enabled by the mask. Reading the cause register returns it and clears it in one access. A soft reset through the control register restores every default and then re-applies the present link level.

Top module: `phy_mgmt_regs`

## Requirements
- R1: `irqOut` is high exactly while the interrupt-cause register (address 29) ANDed with the mask register (address 30) is nonzero. It follows a mask write or a cause change from the same clock edge.
- R2: Cause bits are: 7 energy seen, 6 negotiation done, 5 remote fault, 4 link lost, 3 partner acknowledge, 2 parallel-detect fault, 1 page received. A read of address 29 returns the current causes and leaves the register at zero.
- R3: A write to address 30 stores only `wrData[7:0]`. A read returns that byte zero-extended.
- R4: A write to address 0 with bit 15 clear stores `wrData & 16'h7980`. The kept bits are loopback 14, speed 13, negotiation enable 12, power down 11, duplex 8 and collision test 7. If bit 12 is set, it also sets status bit 5 (negotiation done).
- R5: A write to address 0 with bit 15 set stores none of its other bits. It restores all reset values of R9, and the current link level is applied again on the next clock edge.
- R6: A write to address 4 stores `(wrData & 16'h2D7F) | 16'h0080`, so the 100 half-duplex ability bit 7 is always one.
- R7: When the settled link level falls, status bits 5 and 2 (link up) clear and cause bit 4 sets.
- R8: When the settled link level rises, status bits 5 and 2 set and cause bits 7 and 6 set. The status register then reads 16'h782D.
- R9: After reset, control reads 16'h3000, status 16'h7809, advertisement 16'h01E1, and mask and causes read 0. Once the synchroniser has filled, the link level is applied as in R7 or R8.
- R10: Address 2 reads `ID_HI`, address 3 reads `ID_LO`, address 5 reads 16'h0FE1 and address 6 reads 16'h0001.
- R11: Addresses 17, 18, 27, 31 and every address not listed above read zero. Writes to them, and to addresses 1, 2, 3, 5, 6 and 29, change nothing.
- R12: Only a change of the synchronised link level triggers R7 or R8, `SYNC_STAGES + 1` edges after `linkIn` changes. If that edge also clears address 29 by a read, the read returns the old value and the new causes are kept.
- R13: `rdData` takes the addressed value on the clock edge that samples `rdEn` and holds it while `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 5 | Register address |
| wrData | input | 16 | Write data |
| wrEn | input | 1 | Write strobe, one access per cycle |
| rdEn | input | 1 | Read strobe |
| rdData | output | 16 | Registered read data |
| linkIn | input | 1 | Asynchronous link level, 1 = up |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench builds the block with `SYNC_STAGES = 3` rather than the default 2. The settle window after reset and the edge on which a link change lands are therefore counted against a longer chain. This is also what lets the bench line a read of the cause register up exactly with a link event. The identifier words are overridden with non-default values, so the reads of addresses 2 and 3 show that the parameters reach the read path.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int REG_AW = 5;
  localparam int REG_DW = 16;
  localparam int MASK_W = 8;

  // register addresses
  localparam logic [REG_AW-1:0] ADR_CTRL    = 5'd0;
  localparam logic [REG_AW-1:0] ADR_STAT    = 5'd1;
  localparam logic [REG_AW-1:0] ADR_ID_HI   = 5'd2;
  localparam logic [REG_AW-1:0] ADR_ID_LO   = 5'd3;
  localparam logic [REG_AW-1:0] ADR_ADV     = 5'd4;
  localparam logic [REG_AW-1:0] ADR_PARTNER = 5'd5;
  localparam logic [REG_AW-1:0] ADR_EXPN    = 5'd6;
  localparam logic [REG_AW-1:0] ADR_CAUSE   = 5'd29;
  localparam logic [REG_AW-1:0] ADR_MASK    = 5'd30;

  // bit positions
  localparam int BIT_SOFT_RST  = 15;
  localparam int BIT_NEG_EN    = 12;
  localparam int BIT_NEG_DONE  = 5;
  localparam int BIT_LINK_UP   = 2;
  localparam int CAUSE_ENERGY  = 7;
  localparam int CAUSE_NEGDONE = 6;
  localparam int CAUSE_LINKDN  = 4;

  // keep masks and fixed values
  localparam logic [REG_DW-1:0] CTRL_KEEP   = 16'h7980;
  localparam logic [REG_DW-1:0] CTRL_INIT   = 16'h3000;
  localparam logic [REG_DW-1:0] STAT_INIT   = 16'h7809;
  localparam logic [REG_DW-1:0] ADV_KEEP    = 16'h2D7F;
  localparam logic [REG_DW-1:0] ADV_FORCE   = 16'h0080;
  localparam logic [REG_DW-1:0] ADV_INIT    = 16'h01E1;
  localparam logic [REG_DW-1:0] PARTNER_VAL = 16'h0FE1;
  localparam logic [REG_DW-1:0] EXPN_VAL    = 16'h0001;

  // control -> datapath strobes
  typedef struct packed {
    logic wrCtrl;
    logic softRst;
    logic wrAdv;
    logic wrMask;
    logic rdSample;
    logic rdClrCause;
    logic linkApply;
    logic linkUp;
  } mgmtStrobes_t;

endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              wrEn,
  input  logic              softRstBit,
  input  logic              rdEn,
  input  logic              linkIn,
  output mgmtStrobes_t      strb
);

  localparam int CNT_W = $clog2(SYNC_STAGES + 1);
  localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(SYNC_STAGES);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       fillCnt;
  logic                   fillDone;
  logic                   linkSync;
  logic                   linkPrev;
  logic                   primed;
  logic                   linkEvt;
  logic                   softRstHit;

  // synchroniser chain: variant picked by depth
  if (SYNC_STAGES == 1) begin : g_sync_one
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= linkIn;
    end
  end else begin : g_sync_chain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], linkIn};
    end
  end

  assign linkSync = syncQ[SYNC_STAGES-1];
  assign fillDone = (fillCnt == FILL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          fillCnt <= '0;
    else if (!fillDone) fillCnt <= fillCnt + 1'b1;
  end

  assign softRstHit = wrEn && (regAddr == ADR_CTRL) && softRstBit;
  assign linkEvt    = fillDone && (!primed || (linkSync != linkPrev));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed   <= 1'b0;
      linkPrev <= 1'b0;
    end else if (softRstHit) begin
      primed   <= 1'b0;
    end else if (linkEvt) begin
      primed   <= 1'b1;
      linkPrev <= linkSync;
    end
  end

  always_comb begin
    strb            = '0;
    strb.wrCtrl     = wrEn && (regAddr == ADR_CTRL) && !softRstBit;
    strb.softRst    = softRstHit;
    strb.wrAdv      = wrEn && (regAddr == ADR_ADV);
    strb.wrMask     = wrEn && (regAddr == ADR_MASK);
    strb.rdSample   = rdEn;
    strb.rdClrCause = rdEn && (regAddr == ADR_CAUSE);
    strb.linkApply  = linkEvt && !softRstHit;
    strb.linkUp     = linkSync;
  end

endmodule

// File: rtl/phy_mgmt_dp.sv
module phy_mgmt_dp
  import phy_mgmt_pkg::*;
#(
  parameter logic [REG_DW-1:0] ID_HI = 16'h0123,
  parameter logic [REG_DW-1:0] ID_LO = 16'h4567
) (
  input  logic              clk,
  input  logic              rstN,
  input  mgmtStrobes_t      strb,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] wrData,
  output logic [REG_DW-1:0] rdData,
  output logic              irqOut,
  output logic [REG_DW-1:0] ctrlQ,
  output logic [REG_DW-1:0] statQ,
  output logic [REG_DW-1:0] advQ,
  output logic [MASK_W-1:0] maskQ,
  output logic [MASK_W-1:0] causeQ
);

  logic [REG_DW-1:0] statNext;
  logic [MASK_W-1:0] causeNext;
  logic [REG_DW-1:0] rdMux;

  always_comb begin
    statNext = statQ;
    if (strb.linkApply) begin
      statNext[BIT_NEG_DONE] = strb.linkUp;
      statNext[BIT_LINK_UP]  = strb.linkUp;
    end
    if (strb.wrCtrl && wrData[BIT_NEG_EN]) statNext[BIT_NEG_DONE] = 1'b1;
  end

  always_comb begin
    causeNext = strb.rdClrCause ? '0 : causeQ;
    if (strb.linkApply) begin
      if (strb.linkUp) begin
        causeNext[CAUSE_ENERGY]  = 1'b1;
        causeNext[CAUSE_NEGDONE] = 1'b1;
      end else begin
        causeNext[CAUSE_LINKDN]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= CTRL_INIT;
      statQ  <= STAT_INIT;
      advQ   <= ADV_INIT;
      maskQ  <= '0;
      causeQ <= '0;
    end else if (strb.softRst) begin
      ctrlQ  <= CTRL_INIT;
      statQ  <= STAT_INIT;
      advQ   <= ADV_INIT;
      maskQ  <= '0;
      causeQ <= '0;
    end else begin
      if (strb.wrCtrl) ctrlQ <= wrData & CTRL_KEEP;
      if (strb.wrAdv)  advQ  <= (wrData & ADV_KEEP) | ADV_FORCE;
      if (strb.wrMask) maskQ <= wrData[MASK_W-1:0];
      statQ  <= statNext;
      causeQ <= causeNext;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADR_CTRL:    rdMux = ctrlQ;
      ADR_STAT:    rdMux = statQ;
      ADR_ID_HI:   rdMux = ID_HI;
      ADR_ID_LO:   rdMux = ID_LO;
      ADR_ADV:     rdMux = advQ;
      ADR_PARTNER: rdMux = PARTNER_VAL;
      ADR_EXPN:    rdMux = EXPN_VAL;
      ADR_CAUSE:   rdMux = {{(REG_DW-MASK_W){1'b0}}, causeQ};
      ADR_MASK:    rdMux = {{(REG_DW-MASK_W){1'b0}}, maskQ};
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdData <= '0;
    else if (strb.rdSample) rdData <= rdMux;
  end

  assign irqOut = |(causeQ & maskQ);

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [REG_DW-1:0] ID_HI       = 16'h0123,
  parameter logic [REG_DW-1:0] ID_LO       = 16'h4567
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  input  logic        wrEn,
  input  logic        rdEn,
  output logic [15:0] rdData,
  input  logic        linkIn,
  output logic        irqOut
);

  mgmtStrobes_t      strb;
  logic [REG_DW-1:0] ctrlQ;
  logic [REG_DW-1:0] statQ;
  logic [REG_DW-1:0] advQ;
  logic [MASK_W-1:0] maskQ;
  logic [MASK_W-1:0] causeQ;

  phy_mgmt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .wrEn       (wrEn),
    .softRstBit (wrData[BIT_SOFT_RST]),
    .rdEn       (rdEn),
    .linkIn     (linkIn),
    .strb       (strb)
  );

  phy_mgmt_dp #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regAddr (regAddr),
    .wrData  (wrData),
    .rdData  (rdData),
    .irqOut  (irqOut),
    .ctrlQ   (ctrlQ),
    .statQ   (statQ),
    .advQ    (advQ),
    .maskQ   (maskQ),
    .causeQ  (causeQ)
  );

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk
  import phy_mgmt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        regAddr,
  input logic [15:0]       wrData,
  input logic              wrEn,
  input logic              rdEn,
  input logic [15:0]       rdData,
  input logic              irqOut,
  input mgmtStrobes_t      strb,
  input logic [REG_DW-1:0] ctrlQ,
  input logic [REG_DW-1:0] statQ,
  input logic [REG_DW-1:0] advQ,
  input logic [MASK_W-1:0] maskQ,
  input logic [MASK_W-1:0] causeQ
);

  p_mask_zero_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADR_MASK && wrData[7:0] == 8'h00) |=> !irqOut);

  p_read_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdClrCause && !strb.linkApply && !strb.softRst) |=> (causeQ == 8'h00 && !irqOut));

  p_ctrl_kept_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtrl |=> ((ctrlQ & ~CTRL_KEEP) == 16'h0000));

  p_neg_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCtrl && wrData[BIT_NEG_EN]) |=> statQ[BIT_NEG_DONE]);

  p_soft_reset_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> (ctrlQ == CTRL_INIT && advQ == ADV_INIT && maskQ == 8'h00 && causeQ == 8'h00));

  p_adv_half_forced_r6: assert property (@(posedge clk) disable iff (!rstN)
    advQ[7]);

  p_link_down_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.linkApply && !strb.linkUp) |=> (causeQ[CAUSE_LINKDN] && !statQ[BIT_LINK_UP]));

  p_link_up_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.linkApply && strb.linkUp) |=>
      (causeQ[CAUSE_ENERGY] && causeQ[CAUSE_NEGDONE] && statQ[BIT_LINK_UP] && statQ[BIT_NEG_DONE]));

  p_unimpl_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (regAddr == 5'd17 || regAddr == 5'd31)) |=> (rdData == 16'h0000));

  p_write_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrl, strb.softRst, strb.wrAdv, strb.wrMask}));

  p_read_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind phy_mgmt_regs phy_mgmt_chk i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regAddr (regAddr),
  .wrData  (wrData),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .rdData  (rdData),
  .irqOut  (irqOut),
  .strb    (strb),
  .ctrlQ   (ctrlQ),
  .statQ   (statQ),
  .advQ    (advQ),
  .maskQ   (maskQ),
  .causeQ  (causeQ)
);

// File: tb/test_phy_mgmt_regs.sv
module test_phy_mgmt_regs;

  localparam int          CLK_PERIOD = 10;
  localparam int          SYNC_N     = 3;
  localparam logic [15:0] ID_HI_T    = 16'hA5C3;
  localparam logic [15:0] ID_LO_T    = 16'h3C5A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic        linkIn = 1'b0;
  logic        irqOut;

  int    nCompared = 0;
  int    nMismatch = 0;
  bit    finished  = 0;
  logic  rdSeen    = 1'b0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_regs #(.SYNC_STAGES(SYNC_N), .ID_HI(ID_HI_T), .ID_LO(ID_LO_T)) i_phy_mgmt_regs (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .wrData  (wrData),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .rdData  (rdData),
    .linkIn  (linkIn),
    .irqOut  (irqOut)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compares registered read data against queued expectations
  always @(posedge clk) rdSeen <= rdEn && rstN;

  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        nCompared++;
        nMismatch++;
        $display("FAIL R13: got %h expected no read result", rdData);
      end else begin
        check(rdData, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    rdEn    = 1'b1;
    wrEn    = 1'b0;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    wrData  = d;
    wrEn    = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    check({15'd0, irqOut}, {15'd0, exp}, tag);
  endtask

  task automatic waitLink();
    repeat (SYNC_N + 3) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nCompared++;
    nMismatch++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    chkIrq(1'b0, "R9");
    rd(5'd0,  16'h3000, "R9");
    rd(5'd1,  16'h7809, "R9");
    rd(5'd4,  16'h01E1, "R9");
    rd(5'd30, 16'h0000, "R9");
    rd(5'd2,  ID_HI_T,  "R10");
    rd(5'd3,  ID_LO_T,  "R10");
    rd(5'd5,  16'h0FE1, "R10");
    rd(5'd6,  16'h0001, "R10");
    // reset re-applied link-down cause, then read-clear
    rd(5'd29, 16'h0010, "R9");
    rd(5'd29, 16'h0000, "R2");

    // R3 mask keeps low byte
    wr(5'd30, 16'h01FF);
    rd(5'd30, 16'h00FF, "R3");
    chkIrq(1'b0, "R1");

    // R8 link up
    linkIn = 1'b1;
    waitLink();
    chkIrq(1'b1, "R8");
    rd(5'd1,  16'h782D, "R8");
    rd(5'd29, 16'h00C0, "R8");
    chkIrq(1'b0, "R2");

    // R7 link down
    wr(5'd30, 16'h0010);
    linkIn = 1'b0;
    waitLink();
    chkIrq(1'b1, "R7");
    rd(5'd1,  16'h7809, "R7");
    linkIn = 1'b1;
    waitLink();
    rd(5'd29, 16'h00D0, "R2");
    chkIrq(1'b0, "R2");

    // R1 masking
    wr(5'd30, 16'h0020);
    linkIn = 1'b0;
    waitLink();
    chkIrq(1'b0, "R1");
    wr(5'd30, 16'h0010);
    chkIrq(1'b1, "R1");
    wr(5'd30, 16'h0000);
    chkIrq(1'b0, "R1");

    // R11 ignored writes and zero reads
    wr(5'd29, 16'hFFFF);
    rd(5'd29, 16'h0010, "R11");
    wr(5'd1, 16'h0000);
    rd(5'd1, 16'h7809, "R11");
    wr(5'd17, 16'hFFFF);
    rd(5'd17, 16'h0000, "R11");
    rd(5'd18, 16'h0000, "R11");
    rd(5'd27, 16'h0000, "R11");
    rd(5'd31, 16'h0000, "R11");
    rd(5'd9,  16'h0000, "R11");

    // R4 control write
    wr(5'd0, 16'h7FFF);
    rd(5'd0, 16'h7980, "R4");
    rd(5'd1, 16'h7829, "R4");
    wr(5'd0, 16'h0000);
    rd(5'd0, 16'h0000, "R4");
    rd(5'd1, 16'h7829, "R4");

    // R6 advertisement
    wr(5'd4, 16'hFFFF);
    rd(5'd4, 16'h2DFF, "R6");
    wr(5'd4, 16'h0000);
    rd(5'd4, 16'h0080, "R6");

    // R5 soft reset
    wr(5'd30, 16'h00FF);
    wr(5'd0, 16'hC000);
    rd(5'd0,  16'h3000, "R5");
    repeat (3) @(negedge clk);
    check(rdData, 16'h3000, "R13");
    rd(5'd4,  16'h01E1, "R5");
    rd(5'd30, 16'h0000, "R5");
    rd(5'd1,  16'h7809, "R5");
    rd(5'd29, 16'h0010, "R5");
    chkIrq(1'b0, "R5");

    // R12 link change landing on a read-clear of the causes
    linkIn = 1'b1;
    repeat (SYNC_N - 1) @(negedge clk);
    rd(5'd29, 16'h0000, "R12");
    rd(5'd29, 16'h00C0, "R12");
    repeat (10) @(negedge clk);
    rd(5'd29, 16'h0000, "R12");

    // R9 reset with link already up
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    waitLink();
    rd(5'd29, 16'h00C0, "R9");
    rd(5'd1,  16'h782D, "R9");

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      nCompared++;
      nMismatch++;
      $display("FAIL R13: got %0d pending reads expected 0", expQ.size());
    end
    finish();
  end

endmodule